// File: doc/BRIEF.md
# Three-Operand NaN Propagation Selector

This combinational unit sits beside the datapath of a fused multiply-add and decides which value comes out when at least one of the three single-precision operands is not a number. The operands are the two multiplicands `a` and `b` and the addend `c`. The unit sorts each operand into signaling NaN, quiet NaN or ordinary value. It then applies one of three priority rules, chosen at run time by a two-bit style input, and drives out the winner with its quiet bit set. It also reports whether the invalid-operation exception must be raised.

The datapath supplies a flag that says whether the product is infinity times zero. Two of the styles give that case special treatment when the addend is a NaN. A default-NaN mode input replaces any propagated value with the canonical quiet NaN. The invalid decision is made the same way in that mode, so the flag still follows the operands. Internally the winner is a two-bit pick code: 0 for `a`, 1 for `b`, 2 for `c` and 3 for the default NaN.

Top module: `nanp_select3`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero; it is quiet when fraction bit 22 is 1 and signaling when it is 0; an all-ones exponent with a zero fraction (infinity) is not a NaN.
- R2: `invalid_out` is 1 whenever any operand is a signaling NaN, under every style and mode.
- R3: With `style_sel` 2'b00, or with the unused code 2'b11, the first NaN in the order a, b, c is returned, and the inf-times-zero flag has no effect.
- R4: With `style_sel` 2'b01 the order is: signaling c, signaling a, signaling b, quiet c, quiet a, then b.
- R5: With `style_sel` 2'b01, if `prod_inf_zero` is 1 and c is a quiet NaN, the default NaN is returned and `invalid_out` is 1.
- R6: With `style_sel` 2'b10 the order is: any NaN in a, then any NaN in c, otherwise b.
- R7: With `style_sel` 2'b10, if `prod_inf_zero` is 1 and some operand is a NaN, c is returned and `invalid_out` is 1.
- R8: When `dflt_mode` is 1 the output is always the default NaN 0x7FC00000, while `invalid_out` takes the same value it would have with `dflt_mode` at 0.
- R9: A propagated operand keeps its sign and payload, and its bit 22 is forced to 1.
- R10: When no operand is a NaN, the output is the default NaN 0x7FC00000 and `invalid_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| op_c | input | 32 | Addend |
| prod_inf_zero | input | 1 | The product is infinity times zero |
| style_sel | input | 2 | Priority style: 00 a-b-c, 01 signaling-first with addend lead, 10 a-c-b, 11 as 00 |
| dflt_mode | input | 1 | Always return the default NaN |
| nan_out | output | 32 | Selected NaN, quieted |
| invalid_out | output | 1 | Invalid-operation exception |

## Verification
The hardest cases are the ones where the style-specific inf-times-zero rule and the signaling-NaN rule apply together. One example is style 01 with an infinity-times-zero product and a signaling addend: c still wins and the flag is raised through the signaling path, not the special case. Another is default-NaN mode combined with the style 10 special case, where the output is forced but the flag must survive. Infinities and zeros are placed in the multiplicand slots and the product flag is driven directly, so these combinations come from the ports alone. The boundary between infinity and the smallest signaling NaN is probed with single-bit fractions.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

   typedef enum logic [1:0] {
      PICK_A    = 2'd0,
      PICK_B    = 2'd1,
      PICK_C    = 2'd2,
      PICK_DFLT = 2'd3
   } pick_e;

   localparam logic [1:0] STY_ABC  = 2'b00;
   localparam logic [1:0] STY_SIGF = 2'b01;
   localparam logic [1:0] STY_ACB  = 2'b10;

   localparam int unsigned N_OPS = 3;
   localparam int unsigned IDX_A = 0;
   localparam int unsigned IDX_B = 1;
   localparam int unsigned IDX_C = 2;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify #(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] value_in,
   output logic                  is_qnan,
   output logic                  is_snan
);
   localparam int unsigned W = 1 + EXP_W + FRAC_W;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_full;
   logic              frac_any;
   logic              sign_unused;

   assign sign_unused = value_in[W-1];
   assign exp_f       = value_in[W-2:FRAC_W];
   assign frac_f      = value_in[FRAC_W-1:0];
   assign exp_full    = &exp_f;
   assign frac_any    = |frac_f;

   always_comb begin
      is_qnan = exp_full &  frac_f[FRAC_W-1];
      is_snan = exp_full & ~frac_f[FRAC_W-1] & frac_any;
   end

   // R1: the two kinds never overlap, and both need an all-ones exponent
   always_comb begin
      a_r1_kinds_exclusive: assert (!(is_qnan && is_snan));
      if (is_qnan || is_snan)
         a_r1_nan_needs_full_exp: assert (exp_full && frac_any);
   end
endmodule

// File: rtl/nanp_rank.sv
module nanp_rank
   import nanp_pkg::*;
(
   input  logic [N_OPS-1:0] qnan_v,
   input  logic [N_OPS-1:0] snan_v,
   input  logic             prod_inf_zero,
   input  logic [1:0]       style_sel,
   output pick_e            pick,
   output logic             rule_invalid
);
   logic [N_OPS-1:0] any_v;
   logic             some_nan;
   pick_e            pick_abc, pick_sigf, pick_acb;
   logic             inv_sigf, inv_acb;

   assign any_v    = qnan_v | snan_v;
   assign some_nan = |any_v;

   // plain order a, b, c
   always_comb begin
      if (any_v[IDX_A])      pick_abc = PICK_A;
      else if (any_v[IDX_B]) pick_abc = PICK_B;
      else if (any_v[IDX_C]) pick_abc = PICK_C;
      else                   pick_abc = PICK_DFLT;
   end

   // signaling first, addend leading within each class
   always_comb begin
      inv_sigf = 1'b0;
      if (!some_nan) begin
         pick_sigf = PICK_DFLT;
      end else if (prod_inf_zero && qnan_v[IDX_C]) begin
         pick_sigf = PICK_DFLT;
         inv_sigf  = 1'b1;
      end else if (snan_v[IDX_C]) pick_sigf = PICK_C;
      else if (snan_v[IDX_A])     pick_sigf = PICK_A;
      else if (snan_v[IDX_B])     pick_sigf = PICK_B;
      else if (qnan_v[IDX_C])     pick_sigf = PICK_C;
      else if (qnan_v[IDX_A])     pick_sigf = PICK_A;
      else                        pick_sigf = PICK_B;
   end

   // order a, c, b with the inf-times-zero product handing back c
   always_comb begin
      inv_acb = 1'b0;
      if (!some_nan) begin
         pick_acb = PICK_DFLT;
      end else if (prod_inf_zero) begin
         pick_acb = PICK_C;
         inv_acb  = 1'b1;
      end else if (any_v[IDX_A]) pick_acb = PICK_A;
      else if (any_v[IDX_C])     pick_acb = PICK_C;
      else                       pick_acb = PICK_B;
   end

   always_comb begin
      case (style_sel)
         STY_SIGF: begin pick = pick_sigf; rule_invalid = inv_sigf; end
         STY_ACB:  begin pick = pick_acb;  rule_invalid = inv_acb;  end
         default:  begin pick = pick_abc;  rule_invalid = 1'b0;     end
      endcase
   end

   always_comb begin
      // R10: with no NaN present no rule may pick an operand
      if (!some_nan)
         a_r10_no_nan_dflt_pick: assert (pick == PICK_DFLT && !rule_invalid);
      // R5: quiet addend under an inf-times-zero product in style 01
      if (style_sel == STY_SIGF && prod_inf_zero && qnan_v[IDX_C])
         a_r5_sigf_infzero: assert (pick == PICK_DFLT && rule_invalid);
      // R4: a signaling addend outranks everything in style 01
      if (style_sel == STY_SIGF && snan_v[IDX_C])
         a_r4_sigf_snan_c: assert (pick == PICK_C);
      // R3: style 00 never raises a rule-specific flag
      if (style_sel == STY_ABC)
         a_r3_abc_no_rule: assert (!rule_invalid);
   end
endmodule

// File: rtl/nanp_emit.sv
module nanp_emit
   import nanp_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   input  logic [EXP_W+FRAC_W:0] op_c,
   input  pick_e                 pick,
   input  logic                  dflt_mode,
   output logic [EXP_W+FRAC_W:0] nan_out
);
   localparam int unsigned W = 1 + EXP_W + FRAC_W;
   localparam logic [W-1:0] QUIET_MASK = W'(1) << (FRAC_W - 1);
   localparam logic [W-1:0] DFLT_NAN   =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [W-1:0] ops [N_OPS];
   logic [W-1:0] quiet [N_OPS];

   assign ops[IDX_A] = op_a;
   assign ops[IDX_B] = op_b;
   assign ops[IDX_C] = op_c;

   for (genvar g = 0; g < N_OPS; g++) begin : g_quiet
      assign quiet[g] = ops[g] | QUIET_MASK;
   end

   always_comb begin
      if (dflt_mode) begin
         nan_out = DFLT_NAN;
      end else begin
         case (pick)
            PICK_A:  nan_out = quiet[IDX_A];
            PICK_B:  nan_out = quiet[IDX_B];
            PICK_C:  nan_out = quiet[IDX_C];
            default: nan_out = DFLT_NAN;
         endcase
      end
   end

   // R9: a propagated operand differs from its source only in the quiet bit
   always_comb begin
      if (!dflt_mode && pick == PICK_B)
         a_r9_keeps_payload: assert ((nan_out & ~QUIET_MASK) == (op_b & ~QUIET_MASK));
   end
endmodule

// File: rtl/nanp_select3.sv
module nanp_select3
   import nanp_pkg::*;
#(
   parameter int unsigned EXP_W  = 8,
   parameter int unsigned FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] op_a,
   input  logic [EXP_W+FRAC_W:0] op_b,
   input  logic [EXP_W+FRAC_W:0] op_c,
   input  logic                  prod_inf_zero,
   input  logic [1:0]            style_sel,
   input  logic                  dflt_mode,
   output logic [EXP_W+FRAC_W:0] nan_out,
   output logic                  invalid_out
);
   localparam int unsigned W = 1 + EXP_W + FRAC_W;
   localparam logic [W-1:0] DFLT_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_widths
      $error("nanp_select3: EXP_W and FRAC_W must both be at least 2");
   end

   logic [W-1:0]     ops [N_OPS];
   logic [N_OPS-1:0] qnan_v, snan_v;
   pick_e            pick;
   logic             rule_invalid;

   assign ops[IDX_A] = op_a;
   assign ops[IDX_B] = op_b;
   assign ops[IDX_C] = op_c;

   for (genvar g = 0; g < N_OPS; g++) begin : g_class
      nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_class (
         .value_in (ops[g]),
         .is_qnan  (qnan_v[g]),
         .is_snan  (snan_v[g])
      );
   end

   nanp_rank i_rank (
      .qnan_v        (qnan_v),
      .snan_v        (snan_v),
      .prod_inf_zero (prod_inf_zero),
      .style_sel     (style_sel),
      .pick          (pick),
      .rule_invalid  (rule_invalid)
   );

   nanp_emit #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_emit (
      .op_a      (op_a),
      .op_b      (op_b),
      .op_c      (op_c),
      .pick      (pick),
      .dflt_mode (dflt_mode),
      .nan_out   (nan_out)
   );

   assign invalid_out = (|snan_v) | rule_invalid;

   always_comb begin
      // R2: any signaling operand reaches the flag
      if (|snan_v)
         a_r2_snan_raises: assert (invalid_out);
      // R8: forced default output
      if (dflt_mode)
         a_r8_dflt_forced: assert (nan_out == DFLT_NAN);
      // R9: every output is a quiet NaN
      a_r9_out_quiet: assert ((&nan_out[W-2:FRAC_W]) && nan_out[FRAC_W-1]);
      // R7: style 10 hands back the addend under inf-times-zero
      if (style_sel == STY_ACB && prod_inf_zero && (|(qnan_v | snan_v)) && !dflt_mode)
         a_r7_acb_returns_c: assert (nan_out == (op_c | (W'(1) << (FRAC_W - 1))) && invalid_out);
   end
endmodule

// File: tb/test_nanp_select3.sv
module test_nanp_select3;
   localparam int CLK_PERIOD = 10;
   localparam int N_VEC = 24;

   localparam logic [31:0] QA = 32'h7FC0_0AAA, SA = 32'h7F80_0AAA;
   localparam logic [31:0] QB = 32'hFFC0_0BBB, SB = 32'hFF80_0BBB;
   localparam logic [31:0] QC = 32'h7FC0_0CCC, SC = 32'h7F80_0CCC;
   localparam logic [31:0] ONE = 32'h3F80_0000, INF = 32'h7F80_0000, ZRO = 32'h0;
   localparam logic [31:0] DN = 32'h7FC0_0000;
   localparam logic [31:0] XA = 32'h7FC0_0AAA, XB = 32'hFFC0_0BBB, XC = 32'h7FC0_0CCC;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] c;
      logic        iz;
      logic [1:0]  sty;
      logic        dm;
      logic [31:0] exp_out;
      logic        exp_inv;
      logic [23:0] tag;
   } vec_t;

   localparam vec_t VECS [N_VEC] = '{
      '{QA,  QB,  QC,  1'b0, 2'd0, 1'b0, XA, 1'b0, "R3"},
      '{ONE, SB,  QC,  1'b0, 2'd0, 1'b0, XB, 1'b1, "R2"},
      '{ONE, ONE, SC,  1'b0, 2'd0, 1'b0, XC, 1'b1, "R9"},
      '{QA,  SB,  QC,  1'b0, 2'd1, 1'b0, XB, 1'b1, "R4"},
      '{QA,  QB,  QC,  1'b0, 2'd1, 1'b0, XC, 1'b0, "R4"},
      '{SA,  ONE, SC,  1'b0, 2'd1, 1'b0, XC, 1'b1, "R4"},
      '{QA,  QB,  ONE, 1'b0, 2'd1, 1'b0, XA, 1'b0, "R4"},
      '{ONE, QB,  ONE, 1'b0, 2'd1, 1'b0, XB, 1'b0, "R4"},
      '{INF, ZRO, QC,  1'b1, 2'd1, 1'b0, DN, 1'b1, "R5"},
      '{INF, ZRO, SC,  1'b1, 2'd1, 1'b0, XC, 1'b1, "R5"},
      '{ONE, QB,  QC,  1'b0, 2'd2, 1'b0, XC, 1'b0, "R6"},
      '{SA,  QB,  SC,  1'b0, 2'd2, 1'b0, XA, 1'b1, "R6"},
      '{ZRO, INF, QC,  1'b1, 2'd2, 1'b0, XC, 1'b1, "R7"},
      '{ONE, QB,  ONE, 1'b0, 2'd2, 1'b0, XB, 1'b0, "R6"},
      '{SA,  QB,  QC,  1'b0, 2'd0, 1'b1, DN, 1'b1, "R8"},
      '{QA,  QB,  QC,  1'b0, 2'd1, 1'b1, DN, 1'b0, "R8"},
      '{ONE, QB,  QC,  1'b0, 2'd3, 1'b0, XB, 1'b0, "R3"},
      '{ZRO, INF, QC,  1'b1, 2'd0, 1'b0, XC, 1'b0, "R3"},
      '{ONE, ONE, ONE, 1'b0, 2'd0, 1'b0, DN, 1'b0, "R10"},
      '{INF, QB,  ONE, 1'b0, 2'd0, 1'b0, XB, 1'b0, "R1"},
      '{32'h7F80_0001, ONE, ONE, 1'b0, 2'd0, 1'b0, 32'h7FC0_0001, 1'b1, "R1"},
      '{INF, ZRO, ONE, 1'b1, 2'd2, 1'b0, DN, 1'b0, "R10"},
      '{ZRO, INF, SC,  1'b1, 2'd2, 1'b1, DN, 1'b1, "R7"},
      '{32'hFFBF_FFFF, ONE, ONE, 1'b0, 2'd2, 1'b0, 32'hFFFF_FFFF, 1'b1, "R9"}
   };

   logic clk = 1'b0;
   logic [31:0] op_a = '0, op_b = '0, op_c = '0;
   logic        prod_inf_zero = 1'b0;
   logic [1:0]  style_sel = 2'd0;
   logic        dflt_mode = 1'b0;
   logic [31:0] nan_out;
   logic        invalid_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nanp_select3 i_nanp_select3 (
      .op_a          (op_a),
      .op_b          (op_b),
      .op_c          (op_c),
      .prod_inf_zero (prod_inf_zero),
      .style_sel     (style_sel),
      .dflt_mode     (dflt_mode),
      .nan_out       (nan_out),
      .invalid_out   (invalid_out)
   );

   task automatic check32(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fails++;
         $display("FAIL %s nan_out actual=%08h expected=%08h", tag, act, expv);
      end
   endtask

   task automatic check1(input logic [23:0] tag, input logic act, input logic expv);
      n_checks++;
      if (act !== expv) begin
         n_fails++;
         $display("FAIL %s invalid_out actual=%0b expected=%0b", tag, act, expv);
      end
   endtask

   task automatic apply(input vec_t v);
      @(posedge clk);
      #1;
      op_a = v.a; op_b = v.b; op_c = v.c;
      prod_inf_zero = v.iz; style_sel = v.sty; dflt_mode = v.dm;
      @(negedge clk);
      check32(v.tag, nan_out, v.exp_out);
      check1(v.tag, invalid_out, v.exp_inv);
   endtask

   initial begin
      // idle inputs are all zero: no NaN present (R10)
      @(negedge clk);
      check32("R10", nan_out, DN);
      check1("R10", invalid_out, 1'b0);

      for (int i = 0; i < N_VEC; i++) apply(VECS[i]);

      // R2: every style raises the flag for a lone signaling b
      for (int s = 0; s < 4; s++) begin
         apply('{ONE, SB, ONE, 1'b0, 2'(s), 1'b0, XB, 1'b1, "R2"});
      end
      // R8: flag unchanged by the mode in style 01 inf-times-zero case
      apply('{INF, ZRO, QC, 1'b1, 2'd1, 1'b1, DN, 1'b1, "R8"});

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule